// File: doc/BRIEF.md
# Ethernet Transmit Frame Buffer with Start Threshold

This block takes outgoing Ethernet frame data from a CPU-side write port, one 32-bit word at a time, and passes it to a link-side streamer. Each word carries an end-of-frame marker and a count of its valid bytes, so the buffer knows where each frame stops. A configuration strobe sets the start policy. In cut-through mode a frame starts once a set number of its words are held. In store-and-forward mode a frame starts only when all of it is held. Only one frame is on the link at a time. The next frame's start is judged only after the previous frame has fully left or has been aborted.

Each write chooses one of two paths, and the paths handle shortage differently. A word on the abort path is never stalled. If the buffer is full, the word is refused at once with an error. If the link runs dry in the middle of a frame whose latest word came from this path, the frame is cut off with an abort beat. On the wait path, the writer is held while the buffer is full, but only for a parameterised number of cycles. After that the word is dropped with an error. A link-side shortage on this path simply pauses the stream. In store-and-forward mode, a frame that fills the whole buffer before its end marker arrives is aborted and thrown away.

Top module: `eth_txbuf`

## Requirements
- R1: After reset, tx_valid is low and wr_ready is high. The start threshold is 4 words and the mode is cut-through.
- R2: In cut-through mode, the first word of a frame is offered on the link when the number of buffered words is at least the threshold, or when the buffer is full, and not earlier. A threshold of 0 acts as 1. The next frame is judged only after the previous frame has ended.
- R3: In store-and-forward mode, a frame is offered only after its end-of-frame word is buffered, however many words are held.
- R4: In cut-through mode, a frame whose end-of-frame word arrives before the threshold is reached is still sent.
- R5: Words leave in write order with data, end-of-frame flag and byte count unchanged. While tx_ready is low, the link outputs hold their values.
- R6: Suppose the buffer empties mid-frame while tx_ready is high, and the last word sent came from the abort path. Then one beat appears with tx_abort=1, tx_eof=1, tx_data=0 and tx_nb=0. The rest of that frame, up to and including its end-of-frame word, is dropped without output, and later frames are sent normally.
- R7: When the last word sent came from the wait path, a mid-frame empty buffer only pauses tx_valid. No abort beat is produced.
- R8: A wait-path write (wr_wait=1) into a full buffer sees wr_ready low until space appears. If no space appears, then on the TMO_CYC-th cycle of waiting (TMO_CYC at least 2) it is accepted with wr_err=1 and the word is dropped.
- R9: An abort-path write (wr_wait=0) into a full buffer is accepted in its first cycle with wr_err=1 and the word is dropped. A write that finds space has wr_err=0.
- R10: In store-and-forward mode, if the buffer fills while no end-of-frame word is held, an abort beat as in R6 is sent and that frame is dropped through its end-of-frame word.
- R11: A cycle with cfg_we high loads cfg_thr and cfg_sf. Later start decisions use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Load strobe for threshold and mode |
| cfg_thr | input | THR_W | Start threshold in words |
| cfg_sf | input | 1 | 1 selects store-and-forward mode |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write completes this cycle |
| wr_wait | input | 1 | 1 selects the wait path, 0 the abort path |
| wr_data | input | 32 | Write word |
| wr_eof | input | 1 | Word ends its frame |
| wr_nb | input | 2 | Valid bytes in the word, 0 meaning 4 |
| wr_err | output | 1 | Write completed but its word was dropped |
| tx_valid | output | 1 | Link beat offered |
| tx_ready | input | 1 | Link takes the beat |
| tx_data | output | 32 | Link word |
| tx_eof | output | 1 | Last beat of the frame |
| tx_nb | output | 2 | Valid bytes of the beat |
| tx_abort | output | 1 | Frame aborted, set on its final beat |

## Verification
The assertions watch several properties on every cycle. Buffer storage never overflows or underflows. Link outputs stay steady while the link stalls. An abort beat is always a final beat, and nothing is offered while a frame is being dropped. Each frame start is preceded by its condition: a held end-of-frame word in store-and-forward mode, or the threshold, a full buffer or an end marker in cut-through mode. A wait-path error is only ever preceded by a stall. Several things can only be shown by the bench scenarios: the exact start point against the threshold, the abort sequence followed by silent dropping, the exact timeout length, which words are lost, and end-to-end frame order under random link back-pressure.

// File: rtl/etb_pkg.sv
package etb_pkg;
  localparam int WORD_W = 32;
  localparam int NB_W   = 2;

  typedef struct packed {
    logic              wt;
    logic              eof;
    logic [NB_W-1:0]   nb;
    logic [WORD_W-1:0] data;
  } etb_word_t;

  typedef enum logic [1:0] {
    L_IDLE  = 2'd0,
    L_SEND  = 2'd1,
    L_ABORT = 2'd2,
    L_DROP  = 2'd3
  } etb_lst_e;
endpackage

// File: rtl/etb_fifo.sv
module etb_fifo
  import etb_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  etb_word_t       push_ent,
  input  logic            pop,
  output etb_word_t       head,
  output logic [CW-1:0]   count,
  output logic            full,
  output logic            empty,
  output logic            eof_any
);
  etb_word_t         mem [DEPTH];
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d, eofc_q, eofc_d;

  assign head    = mem[rp_q];
  assign count   = cnt_q;
  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign eof_any = (eofc_q != '0);

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    cnt_d  = cnt_q + CW'(push) - CW'(pop);
    eofc_d = eofc_q + CW'(push && push_ent.eof) - CW'(pop && head.eof);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      eofc_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      eofc_q <= eofc_d;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/etb_wr_gate.sv
module etb_wr_gate #(
  parameter int TMO_CYC = 1024,
  localparam int TW = $clog2(TMO_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic wr_wait,
  input  logic full,
  output logic wr_ready,
  output logic wr_err,
  output logic push
);
  logic [TW-1:0] tmo_q, tmo_d;
  logic          hit;

  assign hit      = (tmo_q == TW'(TMO_CYC - 1));
  assign wr_ready = !full || !wr_wait || hit;
  assign wr_err   = wr_valid && full && wr_ready;
  assign push     = wr_valid && !full;

  always_comb begin
    if (wr_valid && wr_wait && full && !hit) tmo_d = tmo_q + TW'(1);
    else                                     tmo_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_q <= '0;
    else        tmo_q <= tmo_d;
  end

  assert_wait_err_after_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_wait && wr_err) |-> $past(wr_valid && !wr_ready));
endmodule

// File: rtl/etb_link_ctl.sv
module etb_link_ctl
  import etb_pkg::*;
#(
  parameter int THR_W = 16,
  parameter int CW    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf,
  input  logic [THR_W-1:0]  thr,
  input  etb_word_t         head,
  input  logic [CW-1:0]     count,
  input  logic              full,
  input  logic              empty,
  input  logic              eof_any,
  output logic              pop,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_eof,
  output logic [NB_W-1:0]   tx_nb,
  output logic              tx_abort
);
  etb_lst_e    st_q, st_d;
  logic        pol_q, pol_d;
  logic [31:0] cnt32, thr_eff;
  logic        start_ok;

  assign cnt32    = 32'(count);
  assign thr_eff  = (thr == '0) ? 32'd1 : 32'(thr);
  assign start_ok = !empty && (eof_any || (!sf && (full || cnt32 >= thr_eff)));

  always_comb begin
    st_d     = st_q;
    pol_d    = pol_q;
    pop      = 1'b0;
    tx_valid = 1'b0;
    tx_data  = '0;
    tx_eof   = 1'b0;
    tx_nb    = '0;
    tx_abort = 1'b0;
    unique case (st_q)
      L_IDLE: begin
        if (sf && full && !eof_any) begin
          st_d = L_ABORT;
        end else if (start_ok) begin
          st_d  = L_SEND;
          pol_d = head.wt;
        end
      end
      L_SEND: begin
        tx_valid = !empty;
        tx_data  = head.data;
        tx_eof   = head.eof;
        tx_nb    = head.nb;
        if (!empty && tx_ready) begin
          pop   = 1'b1;
          pol_d = head.wt;
          if (head.eof) st_d = L_IDLE;
        end else if (empty && tx_ready && !pol_q) begin
          st_d = L_ABORT;
        end
      end
      L_ABORT: begin
        tx_valid = 1'b1;
        tx_eof   = 1'b1;
        tx_abort = 1'b1;
        if (tx_ready) st_d = L_DROP;
      end
      L_DROP: begin
        if (!empty) begin
          pop = 1'b1;
          if (head.eof) st_d = L_IDLE;
        end
      end
      default: st_d = L_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= L_IDLE;
      pol_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pol_q <= pol_d;
    end
  end

  assert_abort_is_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (tx_valid && tx_eof));
  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_DROP) |-> !tx_valid);
  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_abort) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_eof) && $stable(tx_nb)));
  assert_sf_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_SEND && $past(st_q) == L_IDLE && $past(sf)) |-> $past(eof_any));
  assert_ct_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_SEND && $past(st_q) == L_IDLE && !$past(sf)) |->
      $past(eof_any || full || cnt32 >= thr_eff));
endmodule

// File: rtl/eth_txbuf.sv
module eth_txbuf
  import etb_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int TMO_CYC = 1024,
  parameter int THR_W   = 16,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [THR_W-1:0]  cfg_thr,
  input  logic              cfg_sf,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_wait,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_eof,
  input  logic [NB_W-1:0]   wr_nb,
  output logic              wr_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_eof,
  output logic [NB_W-1:0]   tx_nb,
  output logic              tx_abort
);
  logic [1:0]       rs_q;
  logic             rst_s_n;
  logic [THR_W-1:0] thr_q;
  logic             sf_q;
  logic             push, pop, full, empty, eof_any;
  logic [CW-1:0]    count;
  etb_word_t        in_ent, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      thr_q <= THR_W'(4);
      sf_q  <= 1'b0;
    end else if (cfg_we) begin
      thr_q <= cfg_thr;
      sf_q  <= cfg_sf;
    end
  end

  assign in_ent = '{wt: wr_wait, eof: wr_eof, nb: wr_nb, data: wr_data};

  etb_wr_gate #(.TMO_CYC(TMO_CYC)) u_gate (
    .clk(clk), .rst_n(rst_s_n), .wr_valid(wr_valid), .wr_wait(wr_wait),
    .full(full), .wr_ready(wr_ready), .wr_err(wr_err), .push(push)
  );

  etb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s_n), .push(push), .push_ent(in_ent), .pop(pop),
    .head(head), .count(count), .full(full), .empty(empty), .eof_any(eof_any)
  );

  etb_link_ctl #(.THR_W(THR_W), .CW(CW)) u_link (
    .clk(clk), .rst_n(rst_s_n), .sf(sf_q), .thr(thr_q), .head(head),
    .count(count), .full(full), .empty(empty), .eof_any(eof_any), .pop(pop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_eof(tx_eof), .tx_nb(tx_nb), .tx_abort(tx_abort)
  );
endmodule

// File: tb/eth_txbuf_bench.sv
module eth_txbuf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int TMO        = 12;

  logic        clk = 1'b0;
  logic        rst_n, cfg_we, cfg_sf, wr_valid, wr_ready, wr_wait, wr_eof, wr_err;
  logic [15:0] cfg_thr;
  logic [31:0] wr_data, tx_data;
  logic [1:0]  wr_nb, tx_nb;
  logic        tx_valid, tx_ready, tx_eof, tx_abort;

  typedef logic [35:0] beat_t;
  beat_t got[$];
  beat_t exp[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    rdy_mode = 0;
  int    nn;
  bit    ee;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eth_txbuf #(.DEPTH(DEPTH), .TMO_CYC(TMO), .THR_W(16)) u_eth_txbuf (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thr(cfg_thr), .cfg_sf(cfg_sf),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_wait(wr_wait), .wr_data(wr_data),
    .wr_eof(wr_eof), .wr_nb(wr_nb), .wr_err(wr_err), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_eof(tx_eof), .tx_nb(tx_nb),
    .tx_abort(tx_abort)
  );

  function automatic beat_t mk(bit ab, bit eof, logic [1:0] nb, logic [31:0] d);
    return {ab, eof, nb, d};
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0:       tx_ready = 1'b0;
      1:       tx_ready = 1'b1;
      default: tx_ready = ($urandom_range(0, 7) != 0);
    endcase
  end

  always @(negedge clk)
    if (rst_n && tx_valid && tx_ready) got.push_back(mk(tx_abort, tx_eof, tx_nb, tx_data));

  task automatic cfg(int thr, bit sf);
    cfg_we = 1'b1; cfg_thr = 16'(thr); cfg_sf = sf;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic wr_word(logic [31:0] d, bit eof, logic [1:0] nb, bit wt, bit keep,
                         output int n, output bit err);
    wr_valid = 1'b1; wr_data = d; wr_eof = eof; wr_nb = nb; wr_wait = wt;
    n = 0; err = 1'b0;
    forever begin
      @(negedge clk);
      n++;
      if (wr_ready) begin
        err = wr_err;
        break;
      end
      @(posedge clk); #1;
    end
    step(1);
    wr_valid = 1'b0;
    if (keep && !err) exp.push_back(mk(1'b0, eof, nb, d));
  endtask

  task automatic wr_rand(bit eof, bit wt, bit keep);
    int n; bit e;
    wr_word($urandom, eof, 2'($urandom_range(0, 3)), wt, keep, n, e);
  endtask

  task automatic wr_frame(int len, bit wt, bit keep);
    for (int i = 0; i < len; i++) wr_rand(i == len - 1, wt, keep);
  endtask

  task automatic compare(string req);
    int w = 0;
    while (got.size() < exp.size() && w < 3000) begin step(1); w++; end
    step(20);
    check({req, " beat count"}, 64'(got.size()), 64'(exp.size()));
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check({req, " beat content"}, 64'(got[i]), 64'(exp[i]));
    got.delete();
    exp.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-reqs act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_thr = '0; cfg_sf = 1'b0;
    wr_valid = 1'b0; wr_wait = 1'b0; wr_data = '0; wr_eof = 1'b0; wr_nb = '0;
    tx_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(5);

    // R1 reset state
    check("R1 tx_valid after reset", 64'(tx_valid), 64'd0);
    check("R1 wr_ready after reset", 64'(wr_ready), 64'd1);

    // R1 R2 default threshold of 4 in cut-through
    rdy_mode = 0;
    for (int i = 0; i < 3; i++) wr_rand(1'b0, 1'b1, 1'b1);
    step(4);
    check("R2 R1 no start below default threshold", 64'(tx_valid), 64'd0);
    wr_word(32'h1234_5678, 1'b0, 2'd0, 1'b1, 1'b1, nn, ee);
    check("R9 write with space has no error", 64'(ee), 64'd0);
    step(3);
    check("R2 R1 start at default threshold", 64'(tx_valid), 64'd1);
    wr_rand(1'b1, 1'b1, 1'b1);
    rdy_mode = 1;
    compare("R5 default frame");

    // R3 R11 store-and-forward
    rdy_mode = 0;
    cfg(4, 1'b1);
    for (int i = 0; i < 6; i++) wr_rand(1'b0, 1'b1, 1'b1);
    step(5);
    check("R3 R11 no start without end marker", 64'(tx_valid), 64'd0);
    wr_rand(1'b1, 1'b1, 1'b1);
    step(3);
    check("R3 start after end marker", 64'(tx_valid), 64'd1);
    rdy_mode = 1;
    compare("R3 frame");

    // R4 short frame below threshold
    rdy_mode = 0;
    cfg(8, 1'b0);
    wr_frame(2, 1'b1, 1'b1);
    step(3);
    check("R4 R11 short frame starts", 64'(tx_valid), 64'd1);
    rdy_mode = 1;
    compare("R4 frame");

    // R2 threshold zero acts as one
    rdy_mode = 0;
    cfg(0, 1'b0);
    step(5);
    check("R2 empty buffer never starts", 64'(tx_valid), 64'd0);
    wr_rand(1'b0, 1'b1, 1'b1);
    step(3);
    check("R2 zero threshold starts on one word", 64'(tx_valid), 64'd1);
    wr_rand(1'b1, 1'b1, 1'b1);
    rdy_mode = 1;
    compare("R2 zero-threshold frame");

    // R6 abort-path underrun
    cfg(2, 1'b0);
    rdy_mode = 1;
    wr_rand(1'b0, 1'b0, 1'b1);
    wr_rand(1'b0, 1'b0, 1'b1);
    step(10);
    exp.push_back(mk(1'b1, 1'b1, 2'd0, 32'd0));
    wr_rand(1'b0, 1'b0, 1'b0);
    wr_rand(1'b1, 1'b0, 1'b0);
    wr_frame(2, 1'b1, 1'b1);
    compare("R6 underrun abort");

    // R7 wait-path underrun pauses only
    wr_rand(1'b0, 1'b1, 1'b1);
    wr_rand(1'b0, 1'b1, 1'b1);
    step(10);
    check("R7 paused without abort", 64'(tx_valid), 64'd0);
    wr_rand(1'b0, 1'b1, 1'b1);
    wr_rand(1'b1, 1'b1, 1'b1);
    compare("R7 stalled frame");

    // R8 R9 full buffer write paths
    rdy_mode = 0;
    cfg(4, 1'b0);
    for (int i = 0; i < DEPTH; i++) wr_rand(1'b0, 1'b1, 1'b1);
    wr_word(32'hDEAD_0001, 1'b0, 2'd1, 1'b1, 1'b1, nn, ee);
    check("R8 wait-path cycles until timeout", 64'(nn), 64'(TMO));
    check("R8 wait-path timeout error", 64'(ee), 64'd1);
    wr_word(32'hDEAD_0002, 1'b0, 2'd2, 1'b0, 1'b1, nn, ee);
    check("R9 abort-path full cycles", 64'(nn), 64'd1);
    check("R9 abort-path full error", 64'(ee), 64'd1);
    rdy_mode = 1;
    wr_rand(1'b1, 1'b1, 1'b1);
    compare("R8 R9 dropped words absent");

    // R10 oversize frame in store-and-forward
    cfg(4, 1'b1);
    rdy_mode = 1;
    exp.push_back(mk(1'b1, 1'b1, 2'd0, 32'd0));
    for (int i = 0; i < DEPTH + 4; i++) wr_rand(1'b0, 1'b1, 1'b0);
    wr_rand(1'b1, 1'b1, 1'b0);
    wr_frame(3, 1'b1, 1'b1);
    compare("R10 oversize abort");

    // R5 constrained random traffic
    for (int b = 0; b < 4; b++) begin
      rdy_mode = 1;
      cfg($urandom_range(1, 12), 1'($urandom_range(0, 1)));
      rdy_mode = 2;
      for (int f = 0; f < 10; f++) wr_frame($urandom_range(1, 10), 1'b1, 1'b1);
      compare("R5 random traffic");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule